// File: doc/BRIEF.md
# Page-Bounded Stream Data Prefetcher

This block sits beside a second-level cache and watches the stream of miss addresses. It keeps a small table of streams, each bound to its own 4 KB page. A stream becomes active only after two successive data misses land in the same page close together. From then on, every further miss in that page produces a prefetch for the adjacent block in the direction the stream was trained. Prefetches never leave the page, so they cannot touch a translation the program has not already used. Such a request can never fault. Because the requests are speculative, the block drops them freely.

Instruction misses take a simpler path. Each one asks for the next sequential block, and the request is flagged so that the fill goes to a separate stream buffer and not to the cache. All candidate requests pass through a short queue with a valid/ready handshake toward the memory side. A candidate whose address is already waiting in the queue is discarded. A candidate that finds the queue full is also discarded.

Top module: `page_stream_prefetcher`

## Requirements
- R1: After reset, pfValid is 0 and the stream table holds no pages.
- R2: A data miss to a page that no slot holds claims a slot for that page and issues no prefetch. The slot chosen is the lowest-numbered free slot.
- R3: A data miss to a page held by an untrained slot trains that slot if the distance between the two block addresses is 1 to 3 blocks (64-byte blocks, so less than 256 bytes). If the new block is higher, the stream ascends and the block after the miss is prefetched.
- R4: If the new block is lower when training, the stream descends and the block before the miss is prefetched.
- R5: A miss at distance 0 or at 4 or more blocks from the slot's last miss neither trains the slot nor prefetches. It does become the slot's new last miss.
- R6: Every data miss to a page held by a trained slot prefetches the neighbouring block in that slot's direction.
- R7: A prefetch whose block would lie outside the miss's 4 KB page is suppressed. This covers offset 0xFC0 when ascending and offset 0x000 when descending.
- R8: An instruction miss (missIsInstr=1) requests the next block with pfToBuf=1, under the same page limit. It neither claims nor trains a slot. Data prefetches carry pfToBuf=0.
- R9: At most 8 pages are tracked. A data miss to a new page when all slots are full replaces the slot that was least recently allocated or hit.
- R10: Queued requests leave in arrival order. The head stays on pfAddr/pfToBuf with pfValid=1 until a cycle with pfReady=1. A request from a miss is visible on the cycle after the miss.
- R11: A candidate whose address equals the address of any queued entry is discarded, whatever its pfToBuf flag.
- R12: The queue holds 4 entries. A candidate arriving while it holds 4 is discarded, even if the head leaves in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A miss is presented this cycle |
| missAddr | input | 32 | Byte address of the miss |
| missIsInstr | input | 1 | 1 = instruction miss, 0 = data miss |
| pfReady | input | 1 | Memory side accepts the head request |
| pfValid | output | 1 | A prefetch request is pending |
| pfAddr | output | 32 | Block-aligned prefetch address |
| pfToBuf | output | 1 | 1 = fill goes to the instruction stream buffer |

## Verification
The bench probes the training window at its edges. A distance of 0 blocks and a distance of exactly 4 blocks must not train, and 1 block must train. A design with an off-by-one window would start streams on 256-byte jumps or on repeated hits to one block. Page edges are probed in both directions. A design that wraps the offset or carries into the page number would put out a request for a foreign page. Queue pressure is applied with ready held low, with repeated addresses and with a full queue. A faulty design would show up there as a duplicate, a lost head, or a fifth entry. A replacement sequence refreshes an old page before a new one arrives. A slot picker based on allocation order instead of recency would then evict the wrong page, and a later miss would either train or fail to train.

// File: rtl/psp_pkg.sv
package psp_pkg;
  // Strobes from the decision logic to the table and queue
  typedef struct packed {
    logic touch;      // update a slot's last miss and recency
    logic alloc;      // slot takes a new page
    logic activate;   // slot becomes trained
    logic dirDown;    // direction of the current prefetch
    logic push;       // candidate request present
    logic pushInstr;  // candidate targets the stream buffer
  } spStrobe_t;
endpackage

// File: rtl/psp_ctrl.sv
module psp_ctrl #(
  parameter int N          = 8,
  parameter int PTAG_W     = 20,
  parameter int OFF_W      = 6,
  parameter int SLOT_W     = 3,
  parameter int TRAIN_BLKS = 4
) (
  input  logic                         missValid,
  input  logic                         missIsInstr,
  input  logic [PTAG_W-1:0]            missPage,
  input  logic [OFF_W-1:0]             missOff,
  input  logic [N-1:0]                 tblValid,
  input  logic [N-1:0]                 tblActive,
  input  logic [N-1:0]                 tblDown,
  input  logic [N-1:0][PTAG_W-1:0]     tblPage,
  input  logic [N-1:0][OFF_W-1:0]      tblOff,
  input  logic [N-1:0][SLOT_W-1:0]     tblRank,
  output psp_pkg::spStrobe_t           strb,
  output logic [SLOT_W-1:0]            slotSel,
  output logic [OFF_W-1:0]             tgtOff
);
  localparam int DW = OFF_W + 1;

  logic              anyHit, anyFree, hitActive, hitDown;
  logic [SLOT_W-1:0] hitIdx, freeIdx, lruIdx;
  logic [OFF_W-1:0]  hitOff;
  logic [DW-1:0]     diff, absDiff;
  logic              isNeg, isNear, want, goDown;

  always_comb begin
    anyHit = 1'b0; anyFree = 1'b0;
    hitIdx = '0; freeIdx = '0; lruIdx = '0;
    hitOff = '0; hitActive = 1'b0; hitDown = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (tblValid[i] && tblPage[i] == missPage) begin
        anyHit    = 1'b1;
        hitIdx    = SLOT_W'(i);
        hitOff    = tblOff[i];
        hitActive = tblActive[i];
        hitDown   = tblDown[i];
      end
      if (!tblValid[i]) begin
        anyFree = 1'b1;
        freeIdx = SLOT_W'(i);
      end
      if (tblRank[i] == SLOT_W'(N - 1)) lruIdx = SLOT_W'(i);
    end
  end

  assign diff    = {1'b0, missOff} - {1'b0, hitOff};
  assign isNeg   = diff[DW-1];
  assign absDiff = isNeg ? (~diff + DW'(1)) : diff;
  assign isNear  = (diff != '0) && (absDiff < DW'(TRAIN_BLKS));

  always_comb begin
    strb    = '0;
    slotSel = hitIdx;
    tgtOff  = missOff;
    want    = 1'b0;
    goDown  = 1'b0;
    if (missValid) begin
      if (missIsInstr) begin
        want = 1'b1;
      end else if (anyHit) begin
        strb.touch = 1'b1;
        if (hitActive) begin
          want   = 1'b1;
          goDown = hitDown;
        end else if (isNear) begin
          strb.activate = 1'b1;
          want   = 1'b1;
          goDown = isNeg;
        end
      end else begin
        strb.touch = 1'b1;
        strb.alloc = 1'b1;
        slotSel    = anyFree ? freeIdx : lruIdx;
      end
    end
    strb.dirDown = goDown;
    if (want) begin
      if (goDown) begin
        if (missOff != '0) begin
          strb.push = 1'b1;
          tgtOff    = missOff - OFF_W'(1);
        end
      end else if (missOff != '1) begin
        strb.push = 1'b1;
        tgtOff    = missOff + OFF_W'(1);
      end
    end
    strb.pushInstr = strb.push & missIsInstr;
  end
endmodule

// File: rtl/psp_datapath.sv
module psp_datapath #(
  parameter int N      = 8,
  parameter int PTAG_W = 20,
  parameter int OFF_W  = 6,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  psp_pkg::spStrobe_t           strb,
  input  logic [SLOT_W-1:0]            slotSel,
  input  logic [PTAG_W-1:0]            missPage,
  input  logic [OFF_W-1:0]             missOff,
  input  logic [ADDR_W-1:0]            pushAddr,
  input  logic                         pfReady,
  output logic [N-1:0]                 tblValid,
  output logic [N-1:0]                 tblActive,
  output logic [N-1:0]                 tblDown,
  output logic [N-1:0][PTAG_W-1:0]     tblPage,
  output logic [N-1:0][OFF_W-1:0]      tblOff,
  output logic [N-1:0][SLOT_W-1:0]     tblRank,
  output logic                         pfValid,
  output logic [ADDR_W-1:0]            pfAddr,
  output logic                         pfToBuf
);
  // Stream table
  logic [SLOT_W-1:0] selRank;
  always_comb begin
    selRank = '0;
    for (int i = 0; i < N; i++)
      if (SLOT_W'(i) == slotSel) selRank = tblRank[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblValid  <= '0;
      tblActive <= '0;
      tblDown   <= '0;
      tblPage   <= '0;
      tblOff    <= '0;
      for (int i = 0; i < N; i++) tblRank[i] <= SLOT_W'(i);
    end else if (strb.touch) begin
      for (int i = 0; i < N; i++) begin
        if (SLOT_W'(i) == slotSel) begin
          tblRank[i] <= '0;
          tblOff[i]  <= missOff;
          if (strb.alloc) begin
            tblValid[i]  <= 1'b1;
            tblPage[i]   <= missPage;
            tblActive[i] <= 1'b0;
            tblDown[i]   <= 1'b0;
          end
          if (strb.activate) begin
            tblActive[i] <= 1'b1;
            tblDown[i]   <= strb.dirDown;
          end
        end else if (tblRank[i] < selRank) begin
          tblRank[i] <= tblRank[i] + SLOT_W'(1);
        end
      end
    end
  end

  // Request queue, head at entry 0
  logic [DEPTH-1:0][ADDR_W-1:0] qAddr, nAddr;
  logic [DEPTH-1:0]             qInstr, nInstr;
  logic [CNT_W-1:0]             qCount, nCount, wrIdx;
  logic                         isDup, doPop, doPush;

  always_comb begin
    isDup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i) < qCount && qAddr[i] == pushAddr) isDup = 1'b1;
  end

  assign doPop  = (qCount != '0) && pfReady;
  assign doPush = strb.push && !isDup && (qCount < CNT_W'(DEPTH));
  assign wrIdx  = qCount - (doPop ? CNT_W'(1) : CNT_W'(0));

  always_comb begin
    nAddr  = qAddr;
    nInstr = qInstr;
    if (doPop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        nAddr[i]  = qAddr[i+1];
        nInstr[i] = qInstr[i+1];
      end
    end
    if (doPush) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == wrIdx) begin
          nAddr[i]  = pushAddr;
          nInstr[i] = strb.pushInstr;
        end
      end
    end
    nCount = wrIdx + (doPush ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qAddr  <= '0;
      qInstr <= '0;
      qCount <= '0;
    end else begin
      qAddr  <= nAddr;
      qInstr <= nInstr;
      qCount <= nCount;
    end
  end

  assign pfValid = (qCount != '0);
  assign pfAddr  = qAddr[0];
  assign pfToBuf = qInstr[0];
endmodule

// File: rtl/page_stream_prefetcher.sv
module page_stream_prefetcher #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int PAGE_BYTES  = 4096,
  parameter int TRAIN_BYTES = 256,
  parameter int NUM_STREAMS = 8,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missIsInstr,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  output logic              pfToBuf
);
  localparam int BLK_W      = $clog2(BLOCK_BYTES);
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int OFF_W      = PAGE_W - BLK_W;
  localparam int PTAG_W     = ADDR_W - PAGE_W;
  localparam int SLOT_W     = $clog2(NUM_STREAMS);
  localparam int TRAIN_BLKS = TRAIN_BYTES / BLOCK_BYTES;
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1);

  logic [PTAG_W-1:0]            missPage;
  logic [OFF_W-1:0]             missOff, tgtOff;
  logic [BLK_W-1:0]             unusedLowBits;
  logic [ADDR_W-1:0]            pushAddr;
  logic [SLOT_W-1:0]            slotSel;
  psp_pkg::spStrobe_t           strb;
  logic [NUM_STREAMS-1:0]              tblValid, tblActive, tblDown;
  logic [NUM_STREAMS-1:0][PTAG_W-1:0]  tblPage;
  logic [NUM_STREAMS-1:0][OFF_W-1:0]   tblOff;
  logic [NUM_STREAMS-1:0][SLOT_W-1:0]  tblRank;

  assign missPage      = missAddr[ADDR_W-1:PAGE_W];
  assign missOff       = missAddr[PAGE_W-1:BLK_W];
  assign unusedLowBits = missAddr[BLK_W-1:0];
  assign pushAddr      = {missPage, tgtOff, {BLK_W{1'b0}}};

  psp_ctrl #(
    .N(NUM_STREAMS), .PTAG_W(PTAG_W), .OFF_W(OFF_W),
    .SLOT_W(SLOT_W), .TRAIN_BLKS(TRAIN_BLKS)
  ) u_ctrl (
    .missValid(missValid), .missIsInstr(missIsInstr),
    .missPage(missPage), .missOff(missOff),
    .tblValid(tblValid), .tblActive(tblActive), .tblDown(tblDown),
    .tblPage(tblPage), .tblOff(tblOff), .tblRank(tblRank),
    .strb(strb), .slotSel(slotSel), .tgtOff(tgtOff)
  );

  psp_datapath #(
    .N(NUM_STREAMS), .PTAG_W(PTAG_W), .OFF_W(OFF_W), .SLOT_W(SLOT_W),
    .ADDR_W(ADDR_W), .DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotSel(slotSel),
    .missPage(missPage), .missOff(missOff), .pushAddr(pushAddr),
    .pfReady(pfReady),
    .tblValid(tblValid), .tblActive(tblActive), .tblDown(tblDown),
    .tblPage(tblPage), .tblOff(tblOff), .tblRank(tblRank),
    .pfValid(pfValid), .pfAddr(pfAddr), .pfToBuf(pfToBuf)
  );
endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               missValid,
  input logic [ADDR_W-1:0]  missAddr,
  input logic               missIsInstr,
  input logic               pfReady,
  input logic               pfValid,
  input logic [ADDR_W-1:0]  pfAddr,
  input logic               pfToBuf,
  input psp_pkg::spStrobe_t strb,
  input logic [ADDR_W-1:0]  pushAddr
);
  // R1: queue empty on the first cycle out of reset
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pfValid);

  // R2: claiming a slot never trains it or prefetches
  a_r2_alloc_quiet: assert property (@(posedge clk) disable iff (!rstN)
    missValid && strb.alloc |-> !strb.push && !strb.activate);

  // R4: candidate lies on the side of the miss given by the direction
  a_r4_direction: assert property (@(posedge clk) disable iff (!rstN)
    missValid && strb.push && !strb.pushInstr |->
      (strb.dirDown ? (pushAddr < missAddr) : (pushAddr > missAddr)));

  // R7: every candidate stays in the miss's page
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rstN)
    missValid && strb.push |->
      pushAddr[ADDR_W-1:PAGE_W] == missAddr[ADDR_W-1:PAGE_W]);

  // R8: instruction misses leave the stream table alone
  a_r8_instr_no_train: assert property (@(posedge clk) disable iff (!rstN)
    missValid && missIsInstr |-> !strb.touch);

  // R10: head is held while the memory side stalls
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> pfValid && $stable(pfAddr) && $stable(pfToBuf));

  // R10: the queue only drains through an accepted handshake
  a_r10_drain: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pfValid) |-> $past(pfReady));
endmodule

bind page_stream_prefetcher psp_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
  .missIsInstr(missIsInstr), .pfReady(pfReady), .pfValid(pfValid),
  .pfAddr(pfAddr), .pfToBuf(pfToBuf), .strb(strb), .pushAddr(pushAddr)
);

// File: tb/page_stream_prefetcher_tb.sv
module page_stream_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        missIsInstr = 1'b0;
  logic        pfReady = 1'b0;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic        pfToBuf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  page_stream_prefetcher u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missIsInstr(missIsInstr), .pfReady(pfReady),
    .pfValid(pfValid), .pfAddr(pfAddr), .pfToBuf(pfToBuf)
  );

  // Behavioural reference
  int unsigned mPage[8];
  int          mOff[8];
  int          mStamp[8];
  bit          mValid[8], mAct[8], mDown[8];
  int          tick = 0;
  logic [31:0] qa[$];
  bit          qi[$];

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 0; mAct[i] = 0; mDown[i] = 0; mStamp[i] = 0;
    end
    qa.delete(); qi.delete(); tick = 0;
  endtask

  task automatic modelStep(bit mv, logic [31:0] a, bit ins, bit rdy);
    int unsigned pg;
    int o, d, slot, tgt;
    bit want, dn, push, dup;
    int cnt0;
    pg = a >> 12; o = (a >> 6) & 63;
    want = 0; dn = 0; push = 0; tgt = 0;
    cnt0 = qa.size();
    if (mv) begin
      if (ins) want = 1;
      else begin
        slot = -1;
        for (int i = 0; i < 8; i++) if (mValid[i] && mPage[i] == pg) slot = i;
        if (slot >= 0) begin
          if (mAct[slot]) begin want = 1; dn = mDown[slot]; end
          else begin
            d = o - mOff[slot];
            if (d != 0 && d > -4 && d < 4) begin
              mAct[slot] = 1; mDown[slot] = (d < 0);
              want = 1; dn = (d < 0);
            end
          end
          mOff[slot] = o; tick++; mStamp[slot] = tick;
        end else begin
          for (int i = 7; i >= 0; i--) if (!mValid[i]) slot = i;
          if (slot < 0) begin
            slot = 0;
            for (int i = 1; i < 8; i++) if (mStamp[i] < mStamp[slot]) slot = i;
          end
          mValid[slot] = 1; mPage[slot] = pg; mAct[slot] = 0; mDown[slot] = 0;
          mOff[slot] = o; tick++; mStamp[slot] = tick;
        end
      end
      if (want) begin
        if (dn && o != 0) begin push = 1; tgt = o - 1; end
        if (!dn && o != 63) begin push = 1; tgt = o + 1; end
      end
    end
    dup = 0;
    foreach (qa[k]) if (qa[k] == {pg[19:0], 12'(tgt << 6)}) dup = 1;
    if (cnt0 > 0 && rdy) begin void'(qa.pop_front()); void'(qi.pop_front()); end
    if (push && !dup && cnt0 < 4) begin
      qa.push_back({pg[19:0], 12'(tgt << 6)});
      qi.push_back(ins);
    end
  endtask

  task automatic compare(string tag);
    bit expV;
    expV = (qa.size() != 0);
    checks++;
    if (pfValid !== expV ||
        (expV && (pfAddr !== qa[0] || pfToBuf !== qi[0]))) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%h b=%0b expected v=%0b a=%h b=%0b", tag,
               pfValid, pfAddr, pfToBuf, expV,
               expV ? qa[0] : 32'h0, expV ? qi[0] : 1'b0);
    end
  endtask

  // Drive one cycle (called just after a falling edge), compare after next fall
  task automatic cyc(bit mv, logic [31:0] a, bit ins, bit rdy, string tag);
    missValid = mv; missAddr = a; missIsInstr = ins; pfReady = rdy;
    @(posedge clk);
    modelStep(mv, a, ins, rdy);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic dmiss(logic [31:0] a, string tag);
    cyc(1, a, 0, 1, tag);
    cyc(0, 0, 0, 1, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got running expected finished");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    cyc(0, 0, 0, 1, "R1");

    // R2 allocate, R3 ascend, R6 trained stream
    dmiss(32'h1000_0100, "R2");
    dmiss(32'h1000_0180, "R3");
    dmiss(32'h1000_0400, "R6");
    dmiss(32'h1000_0480, "R6");

    // R5 window edges: 4 blocks, 0 blocks, then 1 block
    dmiss(32'h2000_0000, "R5");
    dmiss(32'h2000_0100, "R5");
    dmiss(32'h2000_0000, "R5");
    dmiss(32'h2000_0000, "R5");
    dmiss(32'h2000_0040, "R5");

    // R4 descend
    dmiss(32'h3000_0800, "R4");
    dmiss(32'h3000_07C0, "R4");
    dmiss(32'h3000_0700, "R4");

    // R7 page edges
    dmiss(32'h4000_0F40, "R7");
    dmiss(32'h4000_0FC0, "R7");
    dmiss(32'h5000_0080, "R7");
    dmiss(32'h5000_0000, "R7");

    // R8 instruction path
    cyc(1, 32'h6000_0200, 1, 1, "R8");
    cyc(0, 0, 0, 1, "R8");
    cyc(1, 32'h6000_0FC0, 1, 1, "R8");
    cyc(0, 0, 0, 1, "R8");
    cyc(1, 32'h7000_0000, 1, 1, "R8");
    cyc(0, 0, 0, 1, "R8");
    dmiss(32'h7000_0040, "R8");

    // R10 hold and order, R11 duplicate, R12 full
    cyc(1, 32'h7100_0000, 1, 0, "R10");
    cyc(1, 32'h7100_0100, 1, 0, "R10");
    cyc(1, 32'h7100_0000, 1, 0, "R11");
    cyc(1, 32'h7100_0200, 1, 0, "R11");
    cyc(1, 32'h7100_0300, 1, 0, "R12");
    cyc(1, 32'h7100_0400, 1, 1, "R12");
    cyc(0, 0, 0, 0, "R12");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R10");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R10");

    // R9 replacement by recency
    dmiss(32'h8000_0000, "R9");
    dmiss(32'h9000_0000, "R9");
    dmiss(32'h1000_0500, "R9");
    dmiss(32'hA000_0000, "R9");
    dmiss(32'h2000_0080, "R9");
    dmiss(32'h2000_00C0, "R9");
    dmiss(32'h1000_0600, "R9");

    // Mixed traffic over more pages than slots
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = {12'h0, 8'(8'h40 + ($urandom % 11)), 6'($urandom % 12), 6'($urandom)};
      if ($urandom % 7 == 0) a[11:6] = 6'(($urandom % 2) ? 63 : 0);
      cyc(($urandom % 5) != 0, a, ($urandom % 8) == 0, ($urandom % 10) < 7, "R9");
    end
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, "R10");
    finishRun();
  end
endmodule